// File: doc/BRIEF.md
# System Exception Pending-State Register Block

This block keeps the software-visible pending state of three system exceptions: the non-maskable interrupt, the deferred service call and the periodic timer exception. Software reaches it through a simple word-wide register port with three mapped offsets. The control/state word lets software raise or drop pending bits and read back a summary of what the core is doing. The same word reports the number of the active vector, whether returning from that handler lands at base level, the highest pending vector and whether any external interrupt is waiting. The exception pending bits are reported as well.

A second offset holds the vector-table base address, which is aligned to 128 bytes. A third offset is a reset-control word guarded by a 16-bit key; a keyed write with a reset bit set produces a one-cycle system-reset request. The core also drives an acknowledge input naming the vector it has just taken, and the matching pending bit drops. Priority arbitration lives elsewhere: the highest pending vector and the active vector arrive from outside as inputs.

Top module: `sysexc_regs`

## Requirements
- R1: After reset, nmiPend, pendSvPend, sysTickPend and sysResetReq are 0, rdData is 0 and the vector-table base reads as 0.
- R2: A write to offset 0xD04 with bit 31 set makes nmiPend 1 on the next clock edge. No write clears it.
- R3: A write to 0xD04 with bit 28 set makes pendSvPend 1, and bit 27 alone clears it. When both bits are 1 in one write, pendSvPend becomes 1.
- R4: A write to 0xD04 with bit 26 set makes sysTickPend 1, and bit 25 alone clears it. When both bits are 1 in one write, sysTickPend becomes 1.
- R5: A read of 0xD04 returns activeVec in bits 8:0. It returns bit 11 = 1 when activeVec is 0 or nestedActive is 0, and 0 otherwise.
- R6: A read of 0xD04 places pendVec in bits 20:12, extPendAny in bit 22, sysTickPend in bit 26, pendSvPend in bit 28 and nmiPend in bit 31. All other bits read 0.
- R7: When ackValid is 1 and ackVec is 2, 14 or 15, nmiPend, pendSvPend or sysTickPend respectively clears on that edge. A set bit written in the same cycle wins over the acknowledge, and other ackVec values change nothing.
- R8: A write to 0xD08 stores wrData with bits 6:0 forced to 0, and a read of 0xD08 returns the stored value.
- R9: A write to 0xD0C whose bits 31:16 equal 0x05FA and whose bit 0 or bit 2 is 1 makes sysResetReq 1 for exactly one cycle, starting at the next edge. Without the key, or with neither bit set, sysResetReq stays 0.
- R10: A read of 0xD0C returns 0xFA050000.
- R11: rdData is loaded on the clock edge where rdEn is 1 and holds otherwise. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| activeVec | input | 9 | Vector number of the running handler, 0 if none |
| nestedActive | input | 1 | A preempted handler lies beneath the running one |
| pendVec | input | 9 | Highest pending vector number from the arbiter |
| extPendAny | input | 1 | Some external interrupt (vector 16 and up) is pending |
| ackValid | input | 1 | Core has taken the vector on ackVec |
| ackVec | input | 9 | Vector number being taken |
| nmiPend | output | 1 | Non-maskable interrupt pending |
| pendSvPend | output | 1 | Deferred service call pending |
| sysTickPend | output | 1 | Periodic timer exception pending |
| sysResetReq | output | 1 | One-cycle system-reset request |

## Verification
The assertions assume that wrEn and rdEn are ordinary synchronous strobes and that addr, wrData and the acknowledge inputs are valid on every edge where they matter. They also assume nothing happens to the pending bits except register writes and acknowledges. The stimulus changes inputs only on the falling edge. It keeps reads in cycles without a write or acknowledge, so the read-back state is stable. Random writes to the control/state word are mixed with random acknowledges aimed at the three exception vectors and at other numbers. Directed cases cover the set-and-clear collision, the set-and-acknowledge collision, keyed and unkeyed reset writes, and the alignment of the table base.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 9;
  localparam int NUM_EXC = 3;

  localparam logic [ADDR_W-1:0] OFS_STATE = 12'hD04;
  localparam logic [ADDR_W-1:0] OFS_BASE  = 12'hD08;
  localparam logic [ADDR_W-1:0] OFS_RESET = 12'hD0C;

  localparam logic [15:0] KEY_WRITE = 16'h05FA;
  localparam logic [15:0] KEY_READ  = 16'hFA05;

  // exception slots: 0 = NMI, 1 = deferred service call, 2 = periodic timer
  localparam int EXC_VEC   [NUM_EXC] = '{2, 14, 15};
  localparam int SET_BIT   [NUM_EXC] = '{31, 28, 26};
  localparam int CLR_BIT   [NUM_EXC] = '{-1, 27, 25};

  localparam int RTB_BIT   = 11;
  localparam int PVEC_LSB  = 12;
  localparam int EXTP_BIT  = 22;
  localparam int BASE_ALIGN = 7;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_STATE = 2'd1,
    RD_BASE  = 2'd2,
    RD_RESET = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [NUM_EXC-1:0] pendSet;
    logic [NUM_EXC-1:0] pendClr;
    logic               wrBase;
    logic               rstReq;
    logic               rdLoad;
    rdSel_e             rdSel;
  } strobe_t;

endpackage

// File: rtl/sysexc_ctrl.sv
module sysexc_ctrl
  import sysexc_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           stb
);

  logic hitState;
  logic hitBase;
  logic hitReset;
  logic keyOk;
  logic unusedWrBits;

  assign hitState = (addr == OFS_STATE);
  assign hitBase  = (addr == OFS_BASE);
  assign hitReset = (addr == OFS_RESET);
  assign keyOk    = (wrData[DATA_W-1:16] == KEY_WRITE);
  assign unusedWrBits = ^wrData;

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_exc
    assign stb.pendSet[i] = wrEn && hitState && wrData[SET_BIT[i]];
    if (CLR_BIT[i] >= 0) begin : g_clr
      assign stb.pendClr[i] = wrEn && hitState && wrData[CLR_BIT[i]];
    end else begin : g_noclr
      assign stb.pendClr[i] = 1'b0;
    end
  end

  assign stb.wrBase = wrEn && hitBase;
  assign stb.rstReq = wrEn && hitReset && keyOk && (wrData[0] || wrData[2]);
  assign stb.rdLoad = rdEn;

  always_comb begin
    if (hitState)      stb.rdSel = RD_STATE;
    else if (hitBase)  stb.rdSel = RD_BASE;
    else if (hitReset) stb.rdSel = RD_RESET;
    else               stb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/sysexc_datapath.sv
module sysexc_datapath
  import sysexc_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [VW-1:0]     activeVec,
  input  logic              nestedActive,
  input  logic [VW-1:0]     pendVec,
  input  logic              extPendAny,
  input  logic              ackValid,
  input  logic [VW-1:0]     ackVec,
  output logic [NUM_EXC-1:0] pendQ,
  output logic              sysResetReq,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] baseQ;
  logic [DATA_W-1:0] stateWord;
  logic [DATA_W-1:0] rdNext;
  logic [NUM_EXC-1:0] ackHit;
  logic unusedLowBits;

  assign unusedLowBits = ^wrData[BASE_ALIGN-1:0];

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_pend
    assign ackHit[i] = ackValid && (ackVec == VW'(EXC_VEC[i]));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            pendQ[i] <= 1'b0;
      else if (stb.pendSet[i])              pendQ[i] <= 1'b1;
      else if (stb.pendClr[i] || ackHit[i]) pendQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           baseQ <= '0;
    else if (stb.wrBase) baseQ <= {wrData[DATA_W-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysResetReq <= 1'b0;
    else       sysResetReq <= stb.rstReq;
  end

  always_comb begin
    stateWord = '0;
    stateWord[VW-1:0] = activeVec;
    stateWord[RTB_BIT] = (activeVec == '0) || !nestedActive;
    stateWord[PVEC_LSB +: VW] = pendVec;
    stateWord[EXTP_BIT] = extPendAny;
    for (int i = 0; i < NUM_EXC; i++) begin
      stateWord[SET_BIT[i]] = pendQ[i];
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_STATE: rdNext = stateWord;
      RD_BASE:  rdNext = baseQ;
      RD_RESET: rdNext = {KEY_READ, 16'h0000};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (stb.rdLoad) rdData <= rdNext;
  end

  // R2: a set request always lands
  a_r2_nmi_set: assert property (@(posedge clk) disable iff (!rstN)
    stb.pendSet[0] |=> pendQ[0]);

  // R2: without set or acknowledge the NMI pending bit holds
  a_r2_nmi_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ[0] && !ackHit[0]) |=> pendQ[0]);

  // R3: set wins over clear for the deferred service call
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pendSet[1] && stb.pendClr[1]) |=> pendQ[1]);

  // R4: set wins over clear for the periodic timer
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pendSet[2] && stb.pendClr[2]) |=> pendQ[2]);

  // R7: acknowledge without a concurrent set drops the timer bit
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ackHit[2] && !stb.pendSet[2]) |=> !pendQ[2]);

  // R8: stored base is always aligned after a write
  a_r8_base_aligned: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrBase |=> (baseQ[BASE_ALIGN-1:0] == '0));

  // R11: read data holds when no read is requested
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdLoad |=> $stable(rdData));

endmodule

// File: rtl/sysexc_regs.sv
module sysexc_regs
  import sysexc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [VEC_W-1:0]  activeVec,
  input  logic              nestedActive,
  input  logic [VEC_W-1:0]  pendVec,
  input  logic              extPendAny,
  input  logic              ackValid,
  input  logic [VEC_W-1:0]  ackVec,
  output logic              nmiPend,
  output logic              pendSvPend,
  output logic              sysTickPend,
  output logic              sysResetReq
);

  strobe_t stb;
  logic [NUM_EXC-1:0] pendQ;

  sysexc_ctrl u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .stb    (stb)
  );

  sysexc_datapath #(.VW(VEC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (wrData),
    .activeVec    (activeVec),
    .nestedActive (nestedActive),
    .pendVec      (pendVec),
    .extPendAny   (extPendAny),
    .ackValid     (ackValid),
    .ackVec       (ackVec),
    .pendQ        (pendQ),
    .sysResetReq  (sysResetReq),
    .rdData       (rdData)
  );

  assign nmiPend     = pendQ[0];
  assign pendSvPend  = pendQ[1];
  assign sysTickPend = pendQ[2];

  // R9: a reset request only follows a keyed write with a reset bit
  a_r9_keyed_only: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(wrEn && addr == OFS_RESET &&
                          wrData[31:16] == KEY_WRITE && (wrData[0] || wrData[2])));

  // R9: a keyed reset write always yields the request
  a_r9_keyed_fires: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_RESET && wrData[31:16] == KEY_WRITE && wrData[0])
      |=> sysResetReq);

endmodule

// File: tb/tb_sysexc_regs.sv
module tb_sysexc_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [8:0]  activeVec = '0;
  logic        nestedActive = 1'b0;
  logic [8:0]  pendVec = '0;
  logic        extPendAny = 1'b0;
  logic        ackValid = 1'b0;
  logic [8:0]  ackVec = '0;
  logic        nmiPend, pendSvPend, sysTickPend, sysResetReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit mNmi, mPsv, mSt;

  always #10 clk = ~clk;

  sysexc_regs dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .activeVec(activeVec),
    .nestedActive(nestedActive), .pendVec(pendVec), .extPendAny(extPendAny),
    .ackValid(ackValid), .ackVec(ackVec), .nmiPend(nmiPend),
    .pendSvPend(pendSvPend), .sysTickPend(sysTickPend), .sysResetReq(sysResetReq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] expState(logic [8:0] av, bit nest, logic [8:0] pv,
                                           bit ext, bit n, bit p, bit s);
    logic [31:0] v = '0;
    v[8:0]   = av;
    v[11]    = (av == 0) || !nest;
    v[20:12] = pv;
    v[22]    = ext;
    v[26]    = s;
    v[28]    = p;
    v[31]    = n;
    return v;
  endfunction

  // one clock with an optional write and acknowledge; returns at the negedge
  task automatic cycle(bit w, logic [11:0] a, logic [31:0] d, bit ak, logic [8:0] av);
    wrEn = w; addr = a; wrData = d; ackValid = ak; ackVec = av;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; ackValid = 1'b0;
  endtask

  task automatic doRead(logic [11:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  // model update for a write to the state word plus an acknowledge
  task automatic modelStep(logic [31:0] d, bit ak, logic [8:0] av);
    if (d[31]) mNmi = 1; else if (ak && av == 2) mNmi = 0;
    if (d[28]) mPsv = 1; else if (d[27] || (ak && av == 14)) mPsv = 0;
    if (d[26]) mSt = 1;  else if (d[25] || (ak && av == 15)) mSt = 0;
  endtask

  task automatic checkPend(string req);
    check(req, {29'd0, nmiPend, pendSvPend, sysTickPend}, {29'd0, mNmi, mPsv, mSt});
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4242));
    mNmi = 0; mPsv = 0; mSt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pend", {29'd0, nmiPend, pendSvPend, sysTickPend}, 32'd0);
    check("R1 rstreq", {31'd0, sysResetReq}, 32'd0);
    check("R1 rdData", rdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    doRead(12'hD08, rd);
    check("R1 base", rd, 32'd0);

    // R2 NMI set, no write clears it, ack clears it
    cycle(1, 12'hD04, 32'h8000_0000, 0, 0); modelStep(32'h8000_0000, 0, 0);
    checkPend("R2 set");
    cycle(1, 12'hD04, 32'h0A00_0000, 0, 0); modelStep(32'h0A00_0000, 0, 0);
    checkPend("R2 no write clear");
    cycle(0, 12'h000, 0, 1, 9'd2); modelStep(0, 1, 9'd2);
    checkPend("R7 ack nmi");

    // R3 / R4 set wins over clear
    cycle(1, 12'hD04, 32'h1800_0000, 0, 0); modelStep(32'h1800_0000, 0, 0);
    checkPend("R3 set wins");
    cycle(1, 12'hD04, 32'h0600_0000, 0, 0); modelStep(32'h0600_0000, 0, 0);
    checkPend("R4 set wins");
    cycle(1, 12'hD04, 32'h0800_0000, 0, 0); modelStep(32'h0800_0000, 0, 0);
    checkPend("R3 clear");
    cycle(1, 12'hD04, 32'h0200_0000, 0, 0); modelStep(32'h0200_0000, 0, 0);
    checkPend("R4 clear");

    // R7 set and ack in one cycle: set wins; unrelated ack ignored
    cycle(1, 12'hD04, 32'h0400_0000, 1, 9'd15); modelStep(32'h0400_0000, 1, 9'd15);
    checkPend("R7 set beats ack");
    cycle(0, 12'h000, 0, 1, 9'd3); modelStep(0, 1, 9'd3);
    checkPend("R7 other ack");

    // R5 / R6 state read: nothing active, and nested active handler
    activeVec = 0; nestedActive = 1; pendVec = 9'd40; extPendAny = 1;
    doRead(12'hD04, rd);
    check("R5 idle rtb", rd, expState(0, 1, 9'd40, 1, mNmi, mPsv, mSt));
    activeVec = 9'd300; nestedActive = 1; pendVec = 9'd511; extPendAny = 0;
    doRead(12'hD04, rd);
    check("R5 nested", rd, expState(9'd300, 1, 9'd511, 0, mNmi, mPsv, mSt));
    nestedActive = 0;
    doRead(12'hD04, rd);
    check("R6 single", rd, expState(9'd300, 0, 9'd511, 0, mNmi, mPsv, mSt));

    // R8 base alignment
    cycle(1, 12'hD08, 32'hDEAD_BEFF, 0, 0);
    doRead(12'hD08, rd);
    check("R8 base", rd, 32'hDEAD_BE80);

    // R10 / R11 fixed and unmapped reads
    doRead(12'hD0C, rd);
    check("R10 key read", rd, 32'hFA05_0000);
    doRead(12'hD10, rd);
    check("R11 unmapped", rd, 32'd0);
    rdEn = 1'b0; addr = 12'hD0C;
    @(posedge clk); @(negedge clk);
    check("R11 hold", rdData, 32'd0);

    // R9 reset control
    cycle(1, 12'hD0C, 32'h05FA_0004, 0, 0);
    check("R9 keyed pulse", {31'd0, sysResetReq}, 32'd1);
    cycle(0, 12'h000, 0, 0, 0);
    check("R9 one cycle", {31'd0, sysResetReq}, 32'd0);
    cycle(1, 12'hD0C, 32'h05FB_0001, 0, 0);
    check("R9 bad key", {31'd0, sysResetReq}, 32'd0);
    cycle(1, 12'hD0C, 32'h05FA_0002, 0, 0);
    check("R9 no reset bit", {31'd0, sysResetReq}, 32'd0);
    cycle(1, 12'hD0C, 32'h05FA_0001, 0, 0);
    check("R9 bit0", {31'd0, sysResetReq}, 32'd1);
    cycle(0, 12'h000, 0, 0, 0);

    // random mix for R2 R3 R4 R7 and state reads for R6
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      logic [8:0] av;
      bit ak;
      d = $urandom();
      d = d & 32'h9E00_0000;
      ak = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: av = 9'd2;
        1: av = 9'd14;
        2: av = 9'd15;
        default: av = 9'($urandom_range(16, 511));
      endcase
      cycle(1, 12'hD04, d, ak, av); modelStep(d, ak, av);
      checkPend("R7 random pend");
      if (i % 4 == 0) begin
        activeVec = 9'($urandom_range(0, 511));
        nestedActive = 1'($urandom_range(0, 1));
        pendVec = 9'($urandom_range(0, 511));
        extPendAny = 1'($urandom_range(0, 1));
        doRead(12'hD04, rd);
        check("R6 random read", rd,
              expState(activeVec, nestedActive, pendVec, extPendAny, mNmi, mPsv, mSt));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule